// File: doc/BRIEF.md
# SPI Master Serial Clock Generator

This block derives the serial clock of an SPI master from the system clock. The clock passes a prescaler chosen by a 2-bit select and then a scaler chosen by a 4-bit code. The scaler values are not uniform: the lowest four codes step in twos, and the higher codes double. A double-rate bit halves the overall division. The clock idles at a polarity-selected level. In the same cycle as each SCK transition, the block emits a one-cycle strobe, so a shift register can launch data on the leading edge and capture it on the trailing edge.

Divider settings and polarity are captured continuously while the generator is stopped. While it runs, the settings are frozen and are taken up again only on a frame-start pulse. That pulse restarts the period from its idle phase. When the master input is low, the block acts as a slave and generates no clock.

Top module: `spi_brg`

## Requirements
- R1: Scaler code k selects divide value 2·(k+1) for k = 0..3 (2, 4, 6, 8) and 2^k for k = 4..15 (16 up to 32768).
- R2: Prescaler select values 0, 1, 2 and 3 choose divide values 2, 3, 5 and 7.
- R3: While running, the SCK period in system clocks is N = prescale·scale when dbr = 0 and N = prescale·scale/2 when dbr = 1.
- R4: In every period, SCK is high for floor(N/2) clocks and low for ceil(N/2) clocks. For odd N, the high phase is therefore one clock shorter.
- R5: SCK rests at the level of cpol. Each period opens with its idle phase (the low phase when cpol = 0, the high phase when cpol = 1), followed by the opposite level.
- R6: lead_stb is high for exactly the one cycle in which SCK first shows its non-idle level. trail_stb is high for exactly the cycle in which SCK returns to idle. The two are never high together.
- R7: While enable is low, SCK equals cpol one clock later, both strobes stay low and the count returns to zero. Dropping enable mid-period returns SCK to idle on the next clock without a strobe.
- R8: Changes to pre_sel, scale_code or dbr while running have no effect on the period until a frame_start pulse. That pulse loads the new values and restarts with an idle phase.
- R9: With master low, SCK stays at cpol and no strobes occur, even when enable is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run the generator |
| master | input | 1 | 1 = master mode; 0 = slave, no clock produced |
| cpol | input | 1 | SCK idle level |
| frame_start | input | 1 | One-cycle pulse: load settings and restart the period |
| pre_sel | input | 2 | Prescaler select (2, 3, 5, 7) |
| scale_code | input | 4 | Scaler code |
| dbr | input | 1 | Double-rate: halves the total division |
| sck | output | 1 | Serial clock |
| lead_stb | output | 1 | Leading-edge strobe |
| trail_stb | output | 1 | Trailing-edge strobe |

## Verification
The block has no parameters of its own, so the bench builds it with the package defaults: an 18-bit-plus period counter with the full 16-entry scaler range. This lets the bench sweep every scaler code up to the 32768 divide with the smallest prescaler and dbr set. It also reaches odd periods of 3 and 15 clocks, where the unequal high and low phases show up. The largest product, 7·32768, fits the counter width, and the 224-clock case exercises a disable in the middle of a period.

// File: rtl/brg_pkg.sv
package brg_pkg;
    localparam int PRE_SEL_W    = 2;
    localparam int SCALE_CODE_W = 4;
    localparam int PRE_W        = 3;
    localparam int SCALE_W      = 1 << SCALE_CODE_W;
    localparam int DIV_W        = PRE_W + SCALE_W;

    typedef struct packed {
        logic [PRE_SEL_W-1:0]    pre_sel;
        logic [SCALE_CODE_W-1:0] code;
        logic                    dbr;
        logic                    cpol;
    } brg_cfg_t;

    function automatic logic [PRE_W-1:0] pre_of(input logic [PRE_SEL_W-1:0] sel);
        logic [PRE_W-1:0] v;
        case (sel)
            2'd0:    v = 3'd2;
            2'd1:    v = 3'd3;
            2'd2:    v = 3'd5;
            default: v = 3'd7;
        endcase
        return v;
    endfunction

    function automatic logic [SCALE_W-1:0] scale_of(input logic [SCALE_CODE_W-1:0] code);
        logic [SCALE_W-1:0] v;
        if (code < SCALE_CODE_W'(4))
            v = (SCALE_W'(code) + SCALE_W'(1)) << 1;
        else
            v = SCALE_W'(1) << code;
        return v;
    endfunction
endpackage

// File: rtl/brg_cfg_hold.sv
module brg_cfg_hold
    import brg_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     load,
    input  brg_cfg_t cfg_in,
    output brg_cfg_t cfg_q
);
    typedef struct packed {
        brg_cfg_t cfg;
    } hold_st_t;

    hold_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.cfg = cfg_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg_q = st_q.cfg;
endmodule

// File: rtl/brg_div_calc.sv
module brg_div_calc
    import brg_pkg::*;
(
    input  brg_cfg_t         cfg,
    output logic [DIV_W-1:0] div_len,
    output logic [DIV_W-1:0] idle_len
);
    logic [DIV_W-1:0] prod;
    logic [DIV_W-1:0] half_dn;

    always_comb begin
        prod    = DIV_W'(pre_of(cfg.pre_sel)) * DIV_W'(scale_of(cfg.code));
        div_len = cfg.dbr ? (prod >> 1) : prod;
        half_dn = div_len >> 1;
        // high phase is floor(N/2); idle phase is high when cpol = 1
        idle_len = cfg.cpol ? half_dn : (div_len - half_dn);
    end
endmodule

// File: rtl/brg_phase_gen.sv
module brg_phase_gen #(
    parameter int DIV_W = 19
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             restart,
    input  logic             idle_cur,
    input  logic             idle_next,
    input  logic [DIV_W-1:0] div_len,
    input  logic [DIV_W-1:0] idle_len,
    output logic             sck,
    output logic             lead_stb,
    output logic             trail_stb
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             sck;
        logic             lead;
        logic             trail;
    } ph_st_t;

    ph_st_t st_d, st_q;
    logic   wrap;
    logic   act;

    always_comb begin
        st_d = st_q;
        wrap = (st_q.cnt >= (div_len - DIV_W'(1)));
        act  = 1'b0;
        if (!run) begin
            st_d.cnt   = '0;
            st_d.sck   = idle_next;
            st_d.lead  = 1'b0;
            st_d.trail = 1'b0;
        end else if (restart) begin
            st_d.cnt   = '0;
            st_d.sck   = idle_next;
            st_d.lead  = 1'b0;
            st_d.trail = (st_q.sck != idle_cur);
        end else begin
            st_d.cnt   = wrap ? '0 : (st_q.cnt + DIV_W'(1));
            act        = (st_d.cnt >= idle_len);
            st_d.sck   = act ? ~idle_cur : idle_cur;
            st_d.lead  = act && (st_q.sck == idle_cur);
            st_d.trail = !act && (st_q.sck != idle_cur);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sck       = st_q.sck;
    assign lead_stb  = st_q.lead;
    assign trail_stb = st_q.trail;
endmodule

// File: rtl/spi_brg.sv
module spi_brg
    import brg_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    enable,
    input  logic                    master,
    input  logic                    cpol,
    input  logic                    frame_start,
    input  logic [PRE_SEL_W-1:0]    pre_sel,
    input  logic [SCALE_CODE_W-1:0] scale_code,
    input  logic                    dbr,
    output logic                    sck,
    output logic                    lead_stb,
    output logic                    trail_stb
);
    brg_cfg_t         cfg_in;
    brg_cfg_t         cfg_q;
    logic             run;
    logic             load;
    logic             idle_next;
    logic [DIV_W-1:0] div_len;
    logic [DIV_W-1:0] idle_len;

    always_comb begin
        cfg_in.pre_sel = pre_sel;
        cfg_in.code    = scale_code;
        cfg_in.dbr     = dbr;
        cfg_in.cpol    = cpol;
        run            = enable && master;
        load           = !run || frame_start;
        idle_next      = load ? cpol : cfg_q.cpol;
    end

    brg_cfg_hold u_hold (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (load),
        .cfg_in (cfg_in),
        .cfg_q  (cfg_q)
    );

    brg_div_calc u_calc (
        .cfg      (cfg_q),
        .div_len  (div_len),
        .idle_len (idle_len)
    );

    brg_phase_gen #(
        .DIV_W (DIV_W)
    ) u_phase (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .restart   (frame_start),
        .idle_cur  (cfg_q.cpol),
        .idle_next (idle_next),
        .div_len   (div_len),
        .idle_len  (idle_len),
        .sck       (sck),
        .lead_stb  (lead_stb),
        .trail_stb (trail_stb)
    );
endmodule

// File: rtl/brg_chk.sv
module brg_chk (
    input logic clk,
    input logic rst_n,
    input logic enable,
    input logic master,
    input logic cpol,
    input logic frame_start,
    input logic sck,
    input logic lead_stb,
    input logic trail_stb
);
    // R6
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(lead_stb && trail_stb));

    // R6
    lead_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lead_stb |-> (sck != $past(sck)));

    // R6
    trail_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trail_stb |-> (sck != $past(sck)));

    // R7
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!lead_stb && !trail_stb && sck == $past(cpol)));

    // R9
    slave_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !master |=> (!lead_stb && !trail_stb && sck == $past(cpol)));

    // R5
    no_silent_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && master && !frame_start) |=> (sck == $past(sck) || lead_stb || trail_stb));
endmodule

bind spi_brg brg_chk u_brg_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .enable      (enable),
    .master      (master),
    .cpol        (cpol),
    .frame_start (frame_start),
    .sck         (sck),
    .lead_stb    (lead_stb),
    .trail_stb   (trail_stb)
);

// File: tb/spi_brg_tb.sv
module spi_brg_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0;
    logic       master = 1'b1;
    logic       cpol = 1'b0;
    logic       frame_start = 1'b0;
    logic [1:0] pre_sel = 2'd0;
    logic [3:0] scale_code = 4'd0;
    logic       dbr = 1'b0;
    logic       sck, lead_stb, trail_stb;

    int    checks = 0;
    int    fails = 0;
    bit    cmp_on = 1'b0;
    bit    done = 1'b0;
    string cur_req = "R6";

    // behavioural reference state
    int   m_cnt = 0;
    bit   m_sck = 0, m_lead = 0, m_trail = 0;
    int   m_pre = 0, m_code = 0;
    bit   m_dbr = 0, m_cpol = 0;

    always #4 clk = ~clk;

    spi_brg u_dut (
        .clk (clk), .rst_n (rst_n), .enable (enable), .master (master),
        .cpol (cpol), .frame_start (frame_start), .pre_sel (pre_sel),
        .scale_code (scale_code), .dbr (dbr), .sck (sck),
        .lead_stb (lead_stb), .trail_stb (trail_stb)
    );

    function automatic int pre_val(input int s);
        case (s)
            0: return 2;
            1: return 3;
            2: return 5;
            default: return 7;
        endcase
    endfunction

    function automatic int scale_val(input int c);
        int tbl[16] = '{2, 4, 6, 8, 16, 32, 64, 128, 256, 512, 1024,
                        2048, 4096, 8192, 16384, 32768};
        return tbl[c];
    endfunction

    function automatic int period(input int p, input int c, input bit d);
        int t;
        t = pre_val(p) * scale_val(c);
        return d ? t / 2 : t;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_cnt = 0; m_sck = 0; m_lead = 0; m_trail = 0;
            m_pre = 0; m_code = 0; m_dbr = 0; m_cpol = 0;
        end else if (!(enable && master)) begin
            m_cnt = 0; m_sck = cpol; m_lead = 0; m_trail = 0;
            m_pre = pre_sel; m_code = scale_code; m_dbr = dbr; m_cpol = cpol;
        end else if (frame_start) begin
            m_trail = (m_sck != m_cpol);
            m_lead = 0;
            m_pre = pre_sel; m_code = scale_code; m_dbr = dbr; m_cpol = cpol;
            m_cnt = 0; m_sck = cpol;
        end else begin
            int n, idle;
            bit nxt;
            n = period(m_pre, m_code, m_dbr);
            idle = m_cpol ? n / 2 : n - n / 2;
            m_cnt = (m_cnt + 1) % n;
            nxt = (m_cnt >= idle) ? ~m_cpol : m_cpol;
            m_lead = (nxt != m_sck) && (nxt != m_cpol);
            m_trail = (nxt != m_sck) && (nxt == m_cpol);
            m_sck = nxt;
        end
    end

    always @(negedge clk) begin
        if (cmp_on) begin
            checks++;
            if ({sck, lead_stb, trail_stb} !== {m_sck, m_lead, m_trail}) begin
                fails++;
                $display("FAIL %s: sck/lead/trail actual %b%b%b expected %b%b%b",
                         cur_req, sck, lead_stb, trail_stb, m_sck, m_lead, m_trail);
            end
        end
    end

    task automatic check_int(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic setup(input bit cp, input int p, input int c, input bit d);
        @(negedge clk);
        enable = 1'b0;
        cpol = cp; pre_sel = 2'(p); scale_code = 4'(c); dbr = d;
        @(negedge clk);
        @(negedge clk);
        enable = 1'b1;
    endtask

    task automatic measure(output int per, output int hi);
        per = 0; hi = 0;
        while (!lead_stb) @(negedge clk);
        do begin
            if (sck) hi++;
            per++;
            @(negedge clk);
        end while (!lead_stb);
    endtask

    initial begin
        int per, hi, strobes, bad;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        cmp_on = 1'b1;
        @(negedge clk);
        cur_req = "R7";
        check_int("R7 reset sck", int'(sck), 0);
        check_int("R7 reset strobes", int'(lead_stb) + int'(trail_stb), 0);

        cur_req = "R3";
        setup(0, 0, 0, 0);
        measure(per, hi);
        check_int("R3 period 2x2", per, 4);
        check_int("R4 high 2x2", hi, 2);

        cur_req = "R4";
        setup(0, 1, 0, 1);
        measure(per, hi);
        check_int("R4 odd period", per, 3);
        check_int("R4 odd high", hi, 1);

        cur_req = "R5";
        setup(1, 1, 0, 1);
        check_int("R5 idle high while stopped", int'(sck), 1);
        measure(per, hi);
        check_int("R5 cpol1 period", per, 3);
        check_int("R4 cpol1 high", hi, 1);

        cur_req = "R2";
        for (int p = 0; p < 4; p++) begin
            setup(0, p, 1, 0);
            measure(per, hi);
            check_int("R2 prescaler", per, pre_val(p) * 4);
        end

        cur_req = "R1";
        for (int c = 0; c < 16; c++) begin
            setup(0, 0, c, 1);
            measure(per, hi);
            check_int("R1 scaler code", per, scale_val(c));
            check_int("R4 scaler high", hi, scale_val(c) / 2);
        end

        cur_req = "R4";
        setup(0, 2, 2, 1);
        measure(per, hi);
        check_int("R4 period 15", per, 15);
        check_int("R4 high 15", hi, 7);

        cur_req = "R8";
        setup(0, 0, 0, 0);
        measure(per, hi);
        @(negedge clk);
        scale_code = 4'd3;
        measure(per, hi);
        check_int("R8 change ignored", per, 4);
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
        check_int("R8 restart idle", int'(sck), 0);
        measure(per, hi);
        check_int("R8 new period", per, 16);

        cur_req = "R9";
        setup(0, 0, 0, 0);
        master = 1'b0;
        strobes = 0; bad = 0;
        repeat (30) begin
            @(negedge clk);
            strobes += int'(lead_stb) + int'(trail_stb);
            if (sck != cpol) bad++;
        end
        check_int("R9 slave strobes", strobes, 0);
        check_int("R9 slave sck", bad, 0);
        master = 1'b1;

        cur_req = "R7";
        setup(0, 3, 5, 0);
        while (!sck) @(negedge clk);
        repeat (5) @(negedge clk);
        enable = 1'b0;
        @(negedge clk);
        check_int("R7 disable sck", int'(sck), 0);
        check_int("R7 disable strobes", int'(lead_stb) + int'(trail_stb), 0);
        repeat (3) @(negedge clk);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (195000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule